// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a radix tree of translation entries from memory. A caller presents the virtual address, the kind of access (data read, data write or instruction fetch) and the physical base of the top table. The block then returns either a physical address with a page-size code and the combined permissions, or a fault code.

Before it touches memory, the block checks that the address is canonical. It then reads one 64-bit entry per level over a plain request/response port, with at most one read in flight. Each table at each level has 512 entries. The walk stops early when it finds a 1 GB or 2 MB leaf, when an entry is absent, or when an entry forbids the access. The result is held until the caller takes it, and no new request is accepted before that.

Top module: `ptw_walker`

## Requirements
- R1: When bits 63..48 of the virtual address are not all equal to bit 47, the result is fault code 1 (non-canonical) with level 0, and no memory read is issued.
- R2: The read for level L (L=0..3) goes to address {table base bits 51..12, 9-bit index, 3'b000}. The indices are virtual address bits 47:39, 38:30, 29:21 and 20:12 for L=0..3. The level-0 base comes from req_root, and each later base comes from bits 51..12 of the previous entry.
- R3: Entry bit 0 is the present flag. A clear present flag in the entry read at level L ends the walk with fault code 2 and res_level=L. This check takes precedence over every permission check on that entry.
- R4: The level-3 entry is always a leaf. Its result is size code 0, paddr = {entry[51:12], va[11:0]} and res_level=3, after exactly four reads.
- R5: Entry bit 7 set at level 1 gives a 1 GB leaf: size code 2, paddr = {entry[51:30], va[29:0]}, two reads. The same bit set at level 2 gives a 2 MB leaf: size code 1, paddr = {entry[51:21], va[20:0]}, three reads. Bit 7 at level 0 has no effect.
- R6: For a write, an entry with bit 1 clear ends the walk at that level with fault code 3. Reads and fetches are not affected by bit 1.
- R7: For an instruction fetch, an entry with bit 63 set ends the walk at that level with fault code 4. Reads and writes through such entries succeed. When a write is also denied, the write fault comes first.
- R8: On success, res_wr_ok is the AND of bit 1 over all entries visited, and res_exec_ok is the AND of the inverted bit 63 over the same entries.
- R9: Physical address bits at or above parameter PA_W are zero in every memory read address and in res_paddr, whatever those bits hold in the entries or in req_root.
- R10: Only one memory read is outstanding at a time. mem_req_valid with a stable address is held until mem_req_ready, and the next read is issued only after mem_rsp_valid.
- R11: res_valid and all result fields are held until res_ready. req_ready is low from the accepted request until the result is consumed, and high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_root | input | 52 | Physical base of the top table (4 KB aligned) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Entry physical address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Caller takes the result |
| res_fault | output | 1 | Walk ended in a fault |
| res_fcode | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 write denied, 4 fetch denied |
| res_level | output | 2 | Level at which the walk ended |
| res_paddr | output | 52 | Translated physical address (zero on fault) |
| res_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| res_wr_ok | output | 1 | Write permitted along the path |
| res_exec_ok | output | 1 | Fetch permitted along the path |

## Verification
On every cycle, the assertions check the handshake rules. These are: the single outstanding read, the held request address, the held result, req_ready never high while a walk or result is pending, and zero upper bits in every address the block drives. They also check that a non-canonical request goes straight to a fault without a read. The scenarios exercise what depends on entry contents: the index slice used at each level, early termination on large leaves, the order of fault checks within one entry, and the permission ANDs. Only the scenarios, which compare every read address and every result field with values worked out from the requirements, can show that these are right.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LVL_N   = 4;
  localparam int IDX_W   = 9;
  localparam int PHYS_W  = 52;
  localparam int FRAME_LO = 12;
  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_PS   = 7;
  localparam int BIT_NX   = 63;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_NONCANON = 3'd1, FLT_NOTPRES = 3'd2,
    FLT_WRPROT = 3'd3, FLT_NOEXEC = 3'd4
  } flt_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pgsz_e;

  // 9-bit table index for a level; level 0 takes the highest slice
  function automatic logic [IDX_W-1:0] va_index(input logic [47:0] va, input logic [1:0] lvl);
    case (lvl)
      2'd0:    return va[47:39];
      2'd1:    return va[38:30];
      2'd2:    return va[29:21];
      default: return va[20:12];
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] entry_addr(input logic [PHYS_W-1:FRAME_LO] base,
                                                   input logic [IDX_W-1:0] idx);
    return {base, idx, 3'b000};
  endfunction

  // leaf frame merged with page offset, then clipped to the implemented width
  function automatic logic [PHYS_W-1:0] leaf_paddr(input logic [63:0] pte, input logic [47:0] va,
                                                   input pgsz_e sz, input logic [PHYS_W-1:0] mask);
    logic [PHYS_W-1:0] full;
    case (sz)
      PG_1G:   full = {pte[51:30], va[29:0]};
      PG_2M:   full = {pte[51:21], va[20:0]};
      default: full = {pte[51:12], va[11:0]};
    endcase
    return full & mask;
  endfunction
endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
  parameter int VA_USED = 48
) (
  input  logic [63:0] va,
  output logic        canon_ok
);
  localparam int TOP_N = 64 - VA_USED + 1;
  logic [TOP_N-1:0] top_bits;
  assign top_bits = va[63:VA_USED-1];
  assign canon_ok = (&top_bits) | ~(|top_bits);
  logic unused_lo;
  assign unused_lo = ^va[VA_USED-2:0];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PHYS_W-1:FRAME_LO] base,
  input  logic [47:0]              va,
  input  logic [1:0]               lvl,
  output logic [PHYS_W-1:0]        addr
);
  logic [IDX_W-1:0] idx;
  assign idx  = va_index(va, lvl);
  assign addr = entry_addr(base, idx);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic [63:0]              pte,
  input  logic [1:0]               lvl,
  input  logic [1:0]               acc,
  input  logic [47:0]              va,
  input  logic [PHYS_W-1:0]        pa_mask,
  output logic                     present,
  output logic                     wr_bit,
  output logic                     nx_bit,
  output logic                     wr_deny,
  output logic                     nx_deny,
  output logic                     is_leaf,
  output pgsz_e                    size,
  output logic [PHYS_W-1:FRAME_LO] next_base,
  output logic [PHYS_W-1:0]        leaf_pa
);
  logic ps_bit;
  assign present = pte[BIT_PRES];
  assign wr_bit  = pte[BIT_WR];
  assign nx_bit  = pte[BIT_NX];
  assign ps_bit  = pte[BIT_PS];

  assign wr_deny = (acc == ACC_WRITE) && !wr_bit;
  assign nx_deny = (acc == ACC_FETCH) && nx_bit;

  always_comb begin
    size = PG_4K;
    if (lvl == 2'd1)      size = PG_1G;
    else if (lvl == 2'd2) size = PG_2M;
  end

  assign is_leaf   = (lvl == 2'd3) || (ps_bit && (lvl == 2'd1 || lvl == 2'd2));
  assign next_base = pte[51:12] & pa_mask[51:12];
  assign leaf_pa   = leaf_paddr(pte, va, size, pa_mask);

  logic unused_bits;
  assign unused_bits = ^{pte[62:52], pte[6:2], PA_W[0]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W    = 48,
  parameter int VA_USED = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [51:0] req_root,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [51:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic [2:0]  res_fcode,
  output logic [1:0]  res_level,
  output logic [51:0] res_paddr,
  output logic [1:0]  res_size,
  output logic        res_wr_ok,
  output logic        res_exec_ok
);
  localparam logic [PHYS_W:0]   MASK_WIDE = (53'd1 << PA_W) - 53'd1;
  localparam logic [PHYS_W-1:0] PA_MASK   = MASK_WIDE[PHYS_W-1:0];

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e                      st;
  logic [47:0]              va_q;
  logic [1:0]               acc_q;
  logic [1:0]               lvl_q;
  logic [PHYS_W-1:FRAME_LO] base_q;
  logic                     wr_ok_q, x_ok_q;
  flt_e                     fcode_q;
  logic [1:0]               rlvl_q;
  logic [PHYS_W-1:0]        pa_q;
  pgsz_e                    size_q;

  // named events for the checker
  logic acc_fire, canon_ok, noncanon_acc, rsp_fire;

  logic                     e_present, e_wr, e_nx, e_wr_deny, e_nx_deny, e_leaf;
  pgsz_e                    e_size;
  logic [PHYS_W-1:FRAME_LO] e_next;
  logic [PHYS_W-1:0]        e_pa;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign res_valid     = (st == S_DONE);
  assign acc_fire      = req_valid && req_ready;
  assign noncanon_acc  = acc_fire && !canon_ok;
  assign rsp_fire      = (st == S_WAIT) && mem_rsp_valid;

  ptw_canon_chk #(.VA_USED(VA_USED)) u_canon (
    .va       (req_vaddr),
    .canon_ok (canon_ok)
  );

  ptw_addr_gen u_agen (
    .base (base_q),
    .va   (va_q),
    .lvl  (lvl_q),
    .addr (mem_req_addr)
  );

  ptw_pte_eval #(.PA_W(PA_W)) u_eval (
    .pte       (mem_rsp_data),
    .lvl       (lvl_q),
    .acc       (acc_q),
    .va        (va_q),
    .pa_mask   (PA_MASK),
    .present   (e_present),
    .wr_bit    (e_wr),
    .nx_bit    (e_nx),
    .wr_deny   (e_wr_deny),
    .nx_deny   (e_nx_deny),
    .is_leaf   (e_leaf),
    .size      (e_size),
    .next_base (e_next),
    .leaf_pa   (e_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      wr_ok_q <= 1'b0;
      x_ok_q  <= 1'b0;
      fcode_q <= FLT_NONE;
      rlvl_q  <= '0;
      pa_q    <= '0;
      size_q  <= PG_4K;
    end else begin
      case (st)
        S_IDLE: if (acc_fire) begin
          va_q    <= req_vaddr[47:0];
          acc_q   <= req_acc;
          lvl_q   <= 2'd0;
          base_q  <= req_root[51:12] & PA_MASK[51:12];
          wr_ok_q <= 1'b1;
          x_ok_q  <= 1'b1;
          rlvl_q  <= 2'd0;
          pa_q    <= '0;
          size_q  <= PG_4K;
          if (!canon_ok) begin
            fcode_q <= FLT_NONCANON;
            st      <= S_DONE;
          end else begin
            fcode_q <= FLT_NONE;
            st      <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          wr_ok_q <= wr_ok_q & e_wr;
          x_ok_q  <= x_ok_q & ~e_nx;
          rlvl_q  <= lvl_q;
          if (!e_present) begin
            fcode_q <= FLT_NOTPRES;
            st      <= S_DONE;
          end else if (e_wr_deny) begin
            fcode_q <= FLT_WRPROT;
            st      <= S_DONE;
          end else if (e_nx_deny) begin
            fcode_q <= FLT_NOEXEC;
            st      <= S_DONE;
          end else if (e_leaf) begin
            fcode_q <= FLT_NONE;
            pa_q    <= e_pa;
            size_q  <= e_size;
            st      <= S_DONE;
          end else begin
            base_q  <= e_next;
            lvl_q   <= lvl_q + 2'd1;
            st      <= S_ISSUE;
          end
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end

  assign res_fault   = (fcode_q != FLT_NONE);
  assign res_fcode   = fcode_q;
  assign res_level   = rlvl_q;
  assign res_paddr   = pa_q;
  assign res_size    = size_q;
  assign res_wr_ok   = wr_ok_q;
  assign res_exec_ok = x_ok_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [51:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic        res_ready,
  input logic [2:0]  res_fcode,
  input logic [1:0]  res_level,
  input logic [51:0] res_paddr,
  input logic        noncanon_acc,
  input logic        rsp_fire
);
  localparam logic [52:0] HI_WIDE = ~((53'd1 << PA_W) - 53'd1);
  localparam logic [51:0] HI_MASK = HI_WIDE[51:0];

  logic outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (rsp_fire) outst <= 1'b0;
  end

  AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    noncanon_acc |=> res_valid && res_fcode == 3'd1 && res_level == 2'd0 && !mem_req_valid); // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && outst)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_ADDR_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr & HI_MASK) == 52'd0 && mem_req_addr[2:0] == 3'd0); // R9
  AST_PA_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_paddr & HI_MASK) == 52'd0); // R9
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fcode)
      && $stable(res_level)); // R11
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid && !outst); // R11
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_fcode     (res_fcode),
  .res_level     (res_level),
  .res_paddr     (res_paddr),
  .noncanon_acc  (noncanon_acc),
  .rsp_fire      (rsp_fire)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 48;
  localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;
  localparam logic [63:0] FRAME_MASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic [63:0] e0, e1, e2, e3;
    logic [2:0]  nrd;
    logic [2:0]  fc;
    logic [1:0]  lvl;
    logic [1:0]  sz;
    logic [51:0] pa;
    logic        wok, xok;
  } vec_t;

  localparam logic [63:0] VA_A = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] P0 = 64'h0000_0000_0020_0003;
  localparam logic [63:0] P1 = 64'h0000_0000_0030_0003;
  localparam logic [63:0] P2 = 64'h0000_0000_0040_0003;
  localparam logic [63:0] P3 = 64'h0000_0012_3456_7003;
  localparam int NV = 16;

  // acc: 0 read, 1 write, 2 fetch
  localparam vec_t VECS [NV] = '{
    '{VA_A, 2'd0, P0, P1, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7ABC, 1'b1, 1'b1},
    '{VA_A, 2'd0, P0, 64'h0000_0000_C000_0083, P2, P3, 3'd2, 3'd0, 2'd1, 2'd2, 52'h0_0000_D678_9ABC, 1'b1, 1'b1},
    '{VA_A, 2'd2, P0, P1, 64'h0000_0000_0860_0083, P3, 3'd3, 3'd0, 2'd2, 2'd1, 52'h0_0000_0878_9ABC, 1'b1, 1'b1},
    '{VA_A, 2'd1, 64'h0000_0000_0020_0083, P1, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7ABC, 1'b1, 1'b1},
    '{VA_A, 2'd0, P0, P1, 64'h0000_0000_0040_0002, P3, 3'd3, 3'd2, 2'd2, 2'd0, 52'h0, 1'b1, 1'b1},
    '{VA_A, 2'd1, P0, 64'h0000_0000_0030_0001, P2, P3, 3'd2, 3'd3, 2'd1, 2'd0, 52'h0, 1'b1, 1'b1},
    '{VA_A, 2'd0, P0, 64'h0000_0000_0030_0001, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7ABC, 1'b0, 1'b1},
    '{VA_A, 2'd2, 64'h8000_0000_0020_0003, P1, P2, P3, 3'd1, 3'd4, 2'd0, 2'd0, 52'h0, 1'b1, 1'b1},
    '{VA_A, 2'd1, 64'h8000_0000_0020_0003, P1, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7ABC, 1'b1, 1'b0},
    '{64'h0000_8000_0000_0000, 2'd0, P0, P1, P2, P3, 3'd0, 3'd1, 2'd0, 2'd0, 52'h0, 1'b1, 1'b1},
    '{64'hFFFF_8000_0000_0123, 2'd0, P0, P1, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7123, 1'b1, 1'b1},
    '{VA_A, 2'd0, 64'h000F_0000_0020_0003, P1, P2, 64'h000F_FF12_3456_7003, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_FF12_3456_7ABC, 1'b1, 1'b1},
    '{VA_A, 2'd2, 64'h8000_0000_0020_0002, P1, P2, P3, 3'd1, 3'd2, 2'd0, 2'd0, 52'h0, 1'b1, 1'b1},
    '{64'hFFFF_0000_0000_0000, 2'd2, P0, P1, P2, P3, 3'd0, 3'd1, 2'd0, 2'd0, 52'h0, 1'b1, 1'b1},
    '{64'h0000_7FFF_FFFF_F000, 2'd0, P0, P1, P2, P3, 3'd4, 3'd0, 2'd3, 2'd0, 52'h0_0012_3456_7000, 1'b1, 1'b1},
    '{VA_A, 2'd2, P0, P1, P2, 64'h8000_0012_3456_7003, 3'd4, 3'd4, 2'd3, 2'd0, 52'h0, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [51:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic [2:0]  res_fcode;
  logic [1:0]  res_level;
  logic [51:0] res_paddr;
  logic [1:0]  res_size;
  logic        res_wr_ok, res_exec_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker #(.PA_W(PA_W)) u_ptw_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_fcode(res_fcode), .res_level(res_level), .res_paddr(res_paddr),
    .res_size(res_size), .res_wr_ok(res_wr_ok), .res_exec_ok(res_exec_ok)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] entry_of(input vec_t v, input int k);
    case (k)
      0: return v.e0;
      1: return v.e1;
      2: return v.e2;
      default: return v.e3;
    endcase
  endfunction

  // table frame clipped to PA_W, plus index scaled by eight
  function automatic logic [51:0] exp_addr(input logic [63:0] src, input logic [63:0] va, input int lvl);
    logic [63:0] fr;
    logic [63:0] ix;
    fr = src & FRAME_MASK;
    ix = (va >> (39 - 9*lvl)) & 64'h1FF;
    return 52'(fr | (ix << 3));
  endfunction

  task automatic run_vec(input vec_t v, input int id);
    int reads;
    bit done;
    logic [63:0] src;
    logic [51:0] held_addr;
    reads = 0;
    done = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_acc = v.acc; req_root = ROOT;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 60 && !done; cyc++) begin
      if (res_valid) begin
        done = 1'b1;
      end else begin
        check(!req_ready, "R11", $sformatf("v%0d busy req_ready", id), 64'(req_ready), 64'd0);
        if (mem_req_valid) begin
          src = (reads == 0) ? {12'd0, ROOT} : entry_of(v, reads - 1);
          check(mem_req_addr == exp_addr(src, v.va, reads), (reads == 0) ? "R2" : "R9",
                $sformatf("v%0d addr L%0d", id, reads), 64'(mem_req_addr), 64'(exp_addr(src, v.va, reads)));
          if (id % 3 == 1) begin
            held_addr = mem_req_addr;
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == held_addr, "R10",
                  $sformatf("v%0d stalled request held", id), 64'(mem_req_addr), 64'(held_addr));
          end
          mem_req_ready = 1'b1;
          @(negedge clk);
          mem_req_ready = 1'b0;
          check(!mem_req_valid, "R10", $sformatf("v%0d no second read", id), 64'(mem_req_valid), 64'd0);
          mem_rsp_valid = 1'b1;
          mem_rsp_data = entry_of(v, reads);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          reads++;
        end else begin
          @(negedge clk);
        end
      end
    end
    check(done, "R11", $sformatf("v%0d result arrived", id), 64'(done), 64'd1);
    check(reads == int'(v.nrd), (v.fc == 3'd1) ? "R1" : "R4",
          $sformatf("v%0d read count", id), 64'(reads), 64'(v.nrd));
    check(res_fcode == v.fc, (v.fc == 3'd2) ? "R3" : (v.fc == 3'd3) ? "R6" : (v.fc == 3'd4) ? "R7" : "R5",
          $sformatf("v%0d fault code", id), 64'(res_fcode), 64'(v.fc));
    check(res_fault == (v.fc != 3'd0), "R3", $sformatf("v%0d fault flag", id), 64'(res_fault), 64'(v.fc != 3'd0));
    check(res_level == v.lvl, "R3", $sformatf("v%0d level", id), 64'(res_level), 64'(v.lvl));
    if (v.fc == 3'd0) begin
      check(res_paddr == v.pa, (v.sz == 2'd0) ? "R4" : "R5", $sformatf("v%0d paddr", id), 64'(res_paddr), 64'(v.pa));
      check(res_size == v.sz, "R5", $sformatf("v%0d size", id), 64'(res_size), 64'(v.sz));
      check(res_wr_ok == v.wok, "R8", $sformatf("v%0d wr_ok", id), 64'(res_wr_ok), 64'(v.wok));
      check(res_exec_ok == v.xok, "R8", $sformatf("v%0d exec_ok", id), 64'(res_exec_ok), 64'(v.xok));
    end
    // result held while not consumed
    @(negedge clk);
    check(res_valid && res_fcode == v.fc && !req_ready, "R11", $sformatf("v%0d result held", id),
          64'(res_valid), 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && req_ready, "R11", $sformatf("v%0d released", id), 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !res_valid && !mem_req_valid, "R11", "reset state",
          {61'd0, req_ready, res_valid, mem_req_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !res_valid && !mem_req_valid, "R10", "idle after reset",
          {61'd0, req_ready, res_valid, mem_req_valid}, 64'd4);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // directed: request presented while a result is pending must not start a walk (R11)
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h0000_8000_0000_0000; req_acc = 2'd0; req_root = ROOT;
    @(negedge clk);
    req_vaddr = VA_A;
    repeat (3) @(negedge clk);
    check(res_valid && res_fcode == 3'd1 && !mem_req_valid, "R11", "second request ignored while pending",
          64'(res_fcode), 64'd1);
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(req_ready, "R11", "idle after directed", 64'(req_ready), 64'd1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule